// File: doc/BRIEF.md
# Bus-Mastered Thermal Sensor Poll Sequencer

This block runs temperature measurements for a group of up to four sensing points, even though it has no converter of its own. A built-in timebase starts a sweep at a fixed period. In each sweep the block visits every enabled slot in ascending order. For each slot it drives single-beat transactions on a bus-master port. It first selects the analog sensor through a write to a mux register. Next it selects and enables the converter channel through two more writes. Last it reads the converter's data word until a configurable valid bit reports a finished conversion. The accepted word, shifted right by a programmable amount, goes into that slot's measurement register.

Every target address and every data value is held in a small register file. This lets the sequencer drive any memory-mapped converter and sensor mux. The valid bit is found by its bit position and its polarity. If the valid bit is still not set, the block re-reads after a programmable pause. After a programmable number of reads it gives up on the slot and keeps the old result. Software configures the block and reads the results through a simple synchronous register port.

Top module: `thermal_poll_seq`

## Requirements
- R1: After reset every configuration register and every measurement register reads as zero, and the bus request is low.
- R2: A sweep starts every PERIOD x 256 x SENS_INT clocks. PERIOD is offset 0 bits 9:0. SENS_INT is offset 1 bits 9:0, and offset 1 bits 25:16 hold a separately stored filter interval. If either PERIOD or SENS_INT is zero, no sweep starts.
- R3: Within a sweep, slots are visited in ascending order. Bit n of the enable mask at offset 2 enables slot n, and disabled slots produce no bus traffic.
- R4: For each enabled slot the transaction order is fixed, and the step controls are at offset 3. If bit 0 is set, the block writes the slot's mux value (offset 16+n) to the sensor-mux address (offset 5). If bit 1 is set, the block writes the channel value (offset 9) to the channel-mux address (offset 6), and then the enable value (offset 10) to the enable address (offset 7). Finally the block reads the data address (offset 8). A step whose bit is clear is skipped.
- R5: A read is valid when the data bit selected by offset 4 bits 4:0 equals offset 4 bit 5. Bit 5 set means the valid bit is active high, and bit 5 clear means it is active low.
- R6: After an invalid read, the next read of the same slot is requested no sooner than POLL clocks later. POLL is at offset 11.
- R7: A slot is abandoned after TIMEOUT reads that are all invalid. TIMEOUT is at offset 12, and a value of 0 counts as 1. The slot's measurement then keeps its previous value, and the sweep continues with the next enabled slot.
- R8: A valid word is stored in slot n's measurement register (offset 24+n) as the low 16 bits of the word shifted right by SHIFT. SHIFT is at offset 13 bits 4:0.
- R9: Only one bus transaction is in flight at a time. Request, address, direction and write data stay stable until ready is seen. Each accepted transaction happens exactly once, and the request drops for at least one cycle after it.
- R10: Configuration registers read back what was written, one cycle after the address is presented. Writes to measurement offsets are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register word offset |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Registered read data for the previous cycle's cfg_addr |
| m_req | output | 1 | Bus-master transaction request |
| m_we | output | 1 | Transaction direction, 1 = write |
| m_addr | output | AW | Transaction address |
| m_wdata | output | DW | Write data |
| m_ready | input | 1 | Target accepts the transaction in this cycle |
| m_rdata | input | DW | Read data, valid with m_ready on a read |

## Verification
The bound checker checks the bus-port rules on every cycle: a waiting request stays stable, the request drops after each acceptance, and no request is made while the sequencer is idle. It also checks that every stored result came from an accepted read whose valid bit matched the programmed polarity. Some behaviours can only be shown by the directed scenarios: the exact transaction order for the different step controls and enable masks, the sweep period, re-polling and abandonment, the value kept on timeout, and the stored shift result.

// File: rtl/tps_pkg.sv
package tps_pkg;
  localparam int FIELD_W = 10;
  localparam int CFG_AW  = 5;

  typedef enum logic [2:0] {
    S_IDLE, S_PICK, S_SNS, S_MUX, S_EN, S_RD, S_WAIT
  } seq_state_e;

  localparam logic [CFG_AW-1:0] RA_PERIOD   = 5'd0;
  localparam logic [CFG_AW-1:0] RA_INTV     = 5'd1;
  localparam logic [CFG_AW-1:0] RA_ENMASK   = 5'd2;
  localparam logic [CFG_AW-1:0] RA_WRCTL    = 5'd3;
  localparam logic [CFG_AW-1:0] RA_VALID    = 5'd4;
  localparam logic [CFG_AW-1:0] RA_SNSADDR  = 5'd5;
  localparam logic [CFG_AW-1:0] RA_MUXADDR  = 5'd6;
  localparam logic [CFG_AW-1:0] RA_ENADDR   = 5'd7;
  localparam logic [CFG_AW-1:0] RA_DATAADDR = 5'd8;
  localparam logic [CFG_AW-1:0] RA_MUXVAL   = 5'd9;
  localparam logic [CFG_AW-1:0] RA_ENVAL    = 5'd10;
  localparam logic [CFG_AW-1:0] RA_POLL     = 5'd11;
  localparam logic [CFG_AW-1:0] RA_TMO      = 5'd12;
  localparam logic [CFG_AW-1:0] RA_SHIFT    = 5'd13;
  localparam logic [CFG_AW-1:0] RA_SLOTMUX  = 5'd16;
  localparam logic [CFG_AW-1:0] RA_MEAS     = 5'd24;
endpackage

// File: rtl/tps_regfile.sv
module tps_regfile
  import tps_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NSLOT = 4,
  parameter int RES_W = 16,
  parameter int CW    = 16,
  parameter int SL_W  = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [CFG_AW-1:0]   cfg_addr,
  input  logic [DW-1:0]       cfg_wdata,
  output logic [DW-1:0]       cfg_rdata,
  input  logic                res_we,
  input  logic [SL_W-1:0]     res_slot,
  input  logic [RES_W-1:0]    res_data,
  output logic [FIELD_W-1:0]  period,
  output logic [FIELD_W-1:0]  sens_int,
  output logic [NSLOT-1:0]    en_mask,
  output logic [1:0]          wrctl,
  output logic [5:0]          vmask,
  output logic [AW-1:0]       sns_addr,
  output logic [AW-1:0]       mux_addr,
  output logic [AW-1:0]       en_addr,
  output logic [AW-1:0]       data_addr,
  output logic [DW-1:0]       mux_val,
  output logic [DW-1:0]       en_val,
  output logic [CW-1:0]       poll,
  output logic [CW-1:0]       tmo,
  output logic [4:0]          shift,
  output logic [DW-1:0]       slot_mux [NSLOT]
);
  logic [FIELD_W-1:0] filt_q;
  logic [RES_W-1:0]   meas_v [NSLOT];
  logic [DW-1:0]      rd_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0; sens_int <= '0; filt_q <= '0; en_mask <= '0;
      wrctl <= '0; vmask <= '0; sns_addr <= '0; mux_addr <= '0;
      en_addr <= '0; data_addr <= '0; mux_val <= '0; en_val <= '0;
      poll <= '0; tmo <= '0; shift <= '0;
    end else if (cfg_we) begin
      case (cfg_addr)
        RA_PERIOD:   period    <= cfg_wdata[FIELD_W-1:0];
        RA_INTV: begin
          sens_int <= cfg_wdata[FIELD_W-1:0];
          filt_q   <= cfg_wdata[16+FIELD_W-1:16];
        end
        RA_ENMASK:   en_mask   <= cfg_wdata[NSLOT-1:0];
        RA_WRCTL:    wrctl     <= cfg_wdata[1:0];
        RA_VALID:    vmask     <= cfg_wdata[5:0];
        RA_SNSADDR:  sns_addr  <= cfg_wdata[AW-1:0];
        RA_MUXADDR:  mux_addr  <= cfg_wdata[AW-1:0];
        RA_ENADDR:   en_addr   <= cfg_wdata[AW-1:0];
        RA_DATAADDR: data_addr <= cfg_wdata[AW-1:0];
        RA_MUXVAL:   mux_val   <= cfg_wdata;
        RA_ENVAL:    en_val    <= cfg_wdata;
        RA_POLL:     poll      <= cfg_wdata[CW-1:0];
        RA_TMO:      tmo       <= cfg_wdata[CW-1:0];
        RA_SHIFT:    shift     <= cfg_wdata[4:0];
        default: ;
      endcase
    end
  end

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    logic [DW-1:0]    mux_r;
    logic [RES_W-1:0] meas_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        mux_r  <= '0;
        meas_r <= '0;
      end else begin
        if (cfg_we && cfg_addr == RA_SLOTMUX + CFG_AW'(n)) mux_r <= cfg_wdata;
        if (res_we && res_slot == SL_W'(n)) meas_r <= res_data;
      end
    end
    assign slot_mux[n] = mux_r;
    assign meas_v[n]   = meas_r;
  end

  always_comb begin
    rd_d = '0;
    case (cfg_addr)
      RA_PERIOD:   rd_d = DW'(period);
      RA_INTV:     rd_d = DW'({filt_q, 6'b0, sens_int});
      RA_ENMASK:   rd_d = DW'(en_mask);
      RA_WRCTL:    rd_d = DW'(wrctl);
      RA_VALID:    rd_d = DW'(vmask);
      RA_SNSADDR:  rd_d = DW'(sns_addr);
      RA_MUXADDR:  rd_d = DW'(mux_addr);
      RA_ENADDR:   rd_d = DW'(en_addr);
      RA_DATAADDR: rd_d = DW'(data_addr);
      RA_MUXVAL:   rd_d = mux_val;
      RA_ENVAL:    rd_d = en_val;
      RA_POLL:     rd_d = DW'(poll);
      RA_TMO:      rd_d = DW'(tmo);
      RA_SHIFT:    rd_d = DW'(shift);
      default: ;
    endcase
    for (int n = 0; n < NSLOT; n++) begin
      if (cfg_addr == RA_SLOTMUX + CFG_AW'(n)) rd_d = slot_mux[n];
      if (cfg_addr == RA_MEAS + CFG_AW'(n))    rd_d = DW'(meas_v[n]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= rd_d;
  end
endmodule

// File: rtl/tps_timebase.sv
module tps_timebase
  import tps_pkg::*;
#(
  parameter int PRESCALE = 256
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] period,
  input  logic [FIELD_W-1:0] sens_int,
  output logic               sweep_go
);
  localparam int PC_W = FIELD_W + $clog2(PRESCALE);

  logic [PC_W-1:0]    pre_q;
  logic [PC_W-1:0]    lim;
  logic [FIELD_W-1:0] unit_q;
  logic               tick;

  always_comb begin
    lim  = PC_W'(period) * PC_W'(PRESCALE);
    tick = (pre_q >= lim - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst || period == '0 || sens_int == '0) begin
      pre_q    <= '0;
      unit_q   <= '0;
      sweep_go <= 1'b0;
    end else begin
      sweep_go <= 1'b0;
      if (tick) begin
        pre_q <= '0;
        if (unit_q >= sens_int - 1'b1) begin
          unit_q   <= '0;
          sweep_go <= 1'b1;
        end else begin
          unit_q <= unit_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/tps_sequencer.sv
module tps_sequencer
  import tps_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int NSLOT = 4,
  parameter int RES_W = 16,
  parameter int CW    = 16,
  parameter int SL_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sweep_go,
  input  logic [NSLOT-1:0] en_mask,
  input  logic [1:0]       wrctl,
  input  logic [5:0]       vmask,
  input  logic [AW-1:0]    sns_addr,
  input  logic [AW-1:0]    mux_addr,
  input  logic [AW-1:0]    en_addr,
  input  logic [AW-1:0]    data_addr,
  input  logic [DW-1:0]    mux_val,
  input  logic [DW-1:0]    en_val,
  input  logic [CW-1:0]    poll,
  input  logic [CW-1:0]    tmo,
  input  logic [4:0]       shift,
  input  logic [DW-1:0]    slot_mux [NSLOT],
  output logic             m_req,
  output logic             m_we,
  output logic [AW-1:0]    m_addr,
  output logic [DW-1:0]    m_wdata,
  input  logic             m_ready,
  input  logic [DW-1:0]    m_rdata,
  output logic             res_we,
  output logic [SL_W-1:0]  res_slot,
  output logic [RES_W-1:0] res_data,
  output logic             busy
);
  seq_state_e      st_q;
  logic [SL_W-1:0] slot_q;
  logic [CW-1:0]   reads_q, wcnt_q, tmo_eff;
  logic [AW-1:0]   addr_sel;
  logic [DW-1:0]   data_sel, shifted;
  logic            valid_hit, last_slot;

  always_comb begin
    valid_hit = (m_rdata[vmask[4:0]] == vmask[5]);
    shifted   = m_rdata >> shift;
    last_slot = (slot_q == SL_W'(NSLOT - 1));
    tmo_eff   = (tmo == '0) ? CW'(1) : tmo;
    case (st_q)
      S_SNS:   begin addr_sel = sns_addr; data_sel = slot_mux[slot_q]; end
      S_MUX:   begin addr_sel = mux_addr; data_sel = mux_val; end
      S_EN:    begin addr_sel = en_addr;  data_sel = en_val; end
      default: begin addr_sel = data_addr; data_sel = '0; end
    endcase
  end

  assign busy = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= S_IDLE; slot_q <= '0; reads_q <= '0; wcnt_q <= '0;
      m_req <= 1'b0; m_we <= 1'b0; m_addr <= '0; m_wdata <= '0;
      res_we <= 1'b0; res_slot <= '0; res_data <= '0;
    end else begin
      res_we <= 1'b0;
      case (st_q)
        S_IDLE: if (sweep_go) begin
          slot_q <= '0;
          st_q   <= S_PICK;
        end
        S_PICK: begin
          reads_q <= '0;
          if (en_mask[slot_q]) begin
            if (wrctl[0])      st_q <= S_SNS;
            else if (wrctl[1]) st_q <= S_MUX;
            else               st_q <= S_RD;
          end else if (last_slot) begin
            st_q <= S_IDLE;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
        S_SNS, S_MUX, S_EN, S_RD: begin
          if (!m_req) begin
            m_req   <= 1'b1;
            m_we    <= (st_q != S_RD);
            m_addr  <= addr_sel;
            m_wdata <= data_sel;
          end else if (m_ready) begin
            m_req <= 1'b0;
            case (st_q)
              S_SNS: st_q <= wrctl[1] ? S_MUX : S_RD;
              S_MUX: st_q <= S_EN;
              S_EN:  st_q <= S_RD;
              default: begin
                reads_q <= reads_q + 1'b1;
                if (valid_hit || (reads_q + 1'b1 >= tmo_eff)) begin
                  if (valid_hit) begin
                    res_we   <= 1'b1;
                    res_slot <= slot_q;
                    res_data <= shifted[RES_W-1:0];
                  end
                  if (last_slot) st_q <= S_IDLE;
                  else begin
                    slot_q <= slot_q + 1'b1;
                    st_q   <= S_PICK;
                  end
                end else begin
                  wcnt_q <= poll;
                  st_q   <= S_WAIT;
                end
              end
            endcase
          end
        end
        S_WAIT: begin
          if (wcnt_q <= CW'(1)) st_q <= S_RD;
          else                  wcnt_q <= wcnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/thermal_poll_seq.sv
module thermal_poll_seq
  import tps_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 32,
  parameter int NSLOT    = 4,
  parameter int RES_W    = 16,
  parameter int CW       = 16,
  parameter int PRESCALE = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [AW-1:0]     m_addr,
  output logic [DW-1:0]     m_wdata,
  input  logic              m_ready,
  input  logic [DW-1:0]     m_rdata
);
  localparam int SL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [FIELD_W-1:0] period, sens_int;
  logic [NSLOT-1:0]   en_mask;
  logic [1:0]         wrctl;
  logic [5:0]         vmask;
  logic [AW-1:0]      sns_addr, mux_addr, en_addr, data_addr;
  logic [DW-1:0]      mux_val, en_val;
  logic [CW-1:0]      poll, tmo;
  logic [4:0]         shift;
  logic [DW-1:0]      slot_mux [NSLOT];
  logic               sweep_go, res_we, seq_busy;
  logic [SL_W-1:0]    res_slot;
  logic [RES_W-1:0]   res_data;

  tps_regfile #(.DW(DW), .AW(AW), .NSLOT(NSLOT), .RES_W(RES_W), .CW(CW), .SL_W(SL_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .res_we(res_we), .res_slot(res_slot), .res_data(res_data),
    .period(period), .sens_int(sens_int), .en_mask(en_mask), .wrctl(wrctl), .vmask(vmask),
    .sns_addr(sns_addr), .mux_addr(mux_addr), .en_addr(en_addr), .data_addr(data_addr),
    .mux_val(mux_val), .en_val(en_val), .poll(poll), .tmo(tmo), .shift(shift),
    .slot_mux(slot_mux)
  );

  tps_timebase #(.PRESCALE(PRESCALE)) u_time (
    .clk(clk), .rst(rst), .period(period), .sens_int(sens_int), .sweep_go(sweep_go)
  );

  tps_sequencer #(.DW(DW), .AW(AW), .NSLOT(NSLOT), .RES_W(RES_W), .CW(CW), .SL_W(SL_W)) u_seq (
    .clk(clk), .rst(rst), .sweep_go(sweep_go), .en_mask(en_mask), .wrctl(wrctl),
    .vmask(vmask), .sns_addr(sns_addr), .mux_addr(mux_addr), .en_addr(en_addr),
    .data_addr(data_addr), .mux_val(mux_val), .en_val(en_val), .poll(poll), .tmo(tmo),
    .shift(shift), .slot_mux(slot_mux), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .res_we(res_we),
    .res_slot(res_slot), .res_data(res_data), .busy(seq_busy)
  );
endmodule

// File: rtl/tps_checker.sv
module tps_checker #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          m_req,
  input logic          m_we,
  input logic [AW-1:0] m_addr,
  input logic [DW-1:0] m_wdata,
  input logic          m_ready,
  input logic [DW-1:0] m_rdata,
  input logic          busy,
  input logic          res_we,
  input logic [5:0]    vmask
);
  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ready) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata))); // R9

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_ready) |=> !m_req); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !m_req); // R3

  AST_STORE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(m_req && m_ready && !m_we)); // R8

  AST_STORE_VALIDBIT: assert property (@(posedge clk) disable iff (rst)
    res_we |-> $past(m_rdata[vmask[4:0]] == vmask[5])); // R5
endmodule

bind thermal_poll_seq tps_checker #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
  .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata), .busy(seq_busy),
  .res_we(res_we), .vmask(vmask)
);

// File: tb/thermal_poll_seq_bench.sv
module thermal_poll_seq_bench;
  import tps_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] SNS_A  = 32'h1000_0604;
  localparam logic [31:0] MUX_A  = 32'h2000_000C;
  localparam logic [31:0] EN_A   = 32'h2000_0008;
  localparam logic [31:0] DATA_A = 32'h2000_0040;
  localparam logic [31:0] CHVAL  = 32'h0000_0800;

  logic clk = 1'b0, rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic        m_req, m_we, m_ready;
  logic [31:0] m_addr, m_wdata, m_rdata;

  thermal_poll_seq u_thermal_poll_seq (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ready(m_ready), .m_rdata(m_rdata)
  );

  int total = 0, bad = 0, cyc = 0, lg_n = 0, miss_left = 0;
  bit finished = 0;
  logic [31:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic        lg_we   [64];
  int          lg_t    [64];
  logic [4:0]  r_pos = 5'd12;
  logic        r_pol = 1'b1;
  logic [31:0] salt = '0, cur_mux = '0;
  logic [31:0] mux_tab [4] = '{32'd0, 32'd1, 32'd2, 32'd16};

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] make_word(input logic v);
    logic [31:0] w;
    w = (cur_mux * 16 + 5 + salt) << 13;
    w[r_pos] = r_pol ? v : ~v;
    return w;
  endfunction

  // bus target model: one-cycle ready, logs each accepted transaction
  initial begin
    logic v;
    m_ready = 1'b0; m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_ready) m_ready = 1'b0;
      else if (m_req) begin
        if (m_we) begin
          if (m_addr == SNS_A) cur_mux = m_wdata;
          m_rdata = '0;
        end else begin
          v = (miss_left == 0);
          if (miss_left > 0) miss_left--;
          m_rdata = make_word(v);
        end
        if (lg_n < 64) begin
          lg_addr[lg_n] = m_addr; lg_we[lg_n] = m_we; lg_t[lg_n] = cyc;
          lg_data[lg_n] = m_we ? m_wdata : m_rdata;
        end
        lg_n++;
        m_ready = 1'b1;
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      summary();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a;
    @(posedge clk); @(negedge clk); d = cfg_rdata;
  endtask

  task automatic wait_log(input int n);
    for (int k = 0; k < 5000 && lg_n < n; k++) @(negedge clk);
  endtask

  task automatic one_sweep();
    lg_n = 0;
    wr(RA_PERIOD, 32'd1);
    wait_log(1);
    wr(RA_PERIOD, 32'd0);
    repeat (400) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk(m_req == 1'b0, "R1 req", 32'(m_req), 32'd0);
    rd(RA_PERIOD, d);  chk(d == 0, "R1 period", d, 0);
    rd(RA_ENMASK, d);  chk(d == 0, "R1 enmask", d, 0);
    rd(RA_MEAS, d);    chk(d == 0, "R1 meas0", d, 0);
    rd(RA_SLOTMUX + 5'd3, d); chk(d == 0, "R1 slotmux3", d, 0);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    wr(RA_INTV, 32'h00AB_0002);
    rd(RA_INTV, d); chk(d == 32'h00AB_0002, "R10 intv", d, 32'h00AB_0002);
    wr(RA_MEAS + 5'd1, 32'hDEAD_BEEF);
    rd(RA_MEAS + 5'd1, d); chk(d == 0, "R10 meas ro", d, 0);
    wr(RA_INTV, 32'd2);
  endtask

  task automatic setup_common();
    wr(RA_SNSADDR, SNS_A); wr(RA_MUXADDR, MUX_A); wr(RA_ENADDR, EN_A);
    wr(RA_DATAADDR, DATA_A); wr(RA_MUXVAL, CHVAL); wr(RA_ENVAL, CHVAL);
    wr(RA_VALID, 32'h2C); wr(RA_POLL, 32'd4); wr(RA_TMO, 32'd8);
    for (int n = 0; n < 4; n++) wr(RA_SLOTMUX + 5'(n), mux_tab[n]);
  endtask

  task automatic t_full();
    logic [31:0] d;
    wr(RA_ENMASK, 32'hF); wr(RA_WRCTL, 32'h3); salt = 32'd7;
    one_sweep();
    chk(lg_n == 16, "R9 txn count", 32'(lg_n), 32'd16);
    for (int n = 0; n < 4; n++) begin
      chk(lg_we[4*n] && lg_addr[4*n] == SNS_A && lg_data[4*n] == mux_tab[n], "R4 sns write", lg_data[4*n], mux_tab[n]);
      chk(lg_we[4*n+1] && lg_addr[4*n+1] == MUX_A && lg_data[4*n+1] == CHVAL, "R4 mux write", lg_addr[4*n+1], MUX_A);
      chk(lg_we[4*n+2] && lg_addr[4*n+2] == EN_A && lg_data[4*n+2] == CHVAL, "R4 en write", lg_addr[4*n+2], EN_A);
      chk(!lg_we[4*n+3] && lg_addr[4*n+3] == DATA_A, "R4 read", lg_addr[4*n+3], DATA_A);
      rd(RA_MEAS + 5'(n), d);
      chk(d == (lg_data[4*n+3] & 32'hFFFF), "R8 meas", d, lg_data[4*n+3] & 32'hFFFF);
    end
  endtask

  task automatic t_sparse();
    wr(RA_ENMASK, 32'h5); wr(RA_WRCTL, 32'h1);
    one_sweep();
    chk(lg_n == 4, "R3 sparse count", 32'(lg_n), 32'd4);
    chk(lg_addr[0] == SNS_A && lg_data[0] == mux_tab[0], "R3 slot0 first", lg_data[0], mux_tab[0]);
    chk(!lg_we[1] && lg_addr[1] == DATA_A, "R4 skip adc writes", lg_addr[1], DATA_A);
    chk(lg_addr[2] == SNS_A && lg_data[2] == mux_tab[2], "R3 slot2 next", lg_data[2], mux_tab[2]);
    wr(RA_ENMASK, 32'h2); wr(RA_WRCTL, 32'h0);
    one_sweep();
    chk(lg_n == 1 && !lg_we[0] && lg_addr[0] == DATA_A, "R4 read only", 32'(lg_n), 32'd1);
  endtask

  task automatic t_poll();
    logic [31:0] d;
    wr(RA_ENMASK, 32'h1); wr(RA_WRCTL, 32'h0); wr(RA_POLL, 32'd6);
    salt = 32'd21; miss_left = 2;
    one_sweep();
    chk(lg_n == 3, "R6 read count", 32'(lg_n), 32'd3);
    chk(lg_t[1] - lg_t[0] >= 6, "R6 gap1", 32'(lg_t[1] - lg_t[0]), 32'd6);
    chk(lg_t[2] - lg_t[1] >= 6, "R6 gap2", 32'(lg_t[2] - lg_t[1]), 32'd6);
    rd(RA_MEAS, d); chk(d == (lg_data[2] & 32'hFFFF), "R6 meas", d, lg_data[2] & 32'hFFFF);
  endtask

  task automatic t_polarity();
    logic [31:0] d;
    wr(RA_VALID, 32'h07); r_pos = 5'd7; r_pol = 1'b0;
    wr(RA_SHIFT, 32'd13); salt = 32'd40; miss_left = 1;
    one_sweep();
    chk(lg_n == 2, "R5 low polarity reads", 32'(lg_n), 32'd2);
    rd(RA_MEAS, d);
    chk(d == ((lg_data[1] >> 13) & 32'hFFFF), "R8 shifted", d, (lg_data[1] >> 13) & 32'hFFFF);
    wr(RA_VALID, 32'h2C); r_pos = 5'd12; r_pol = 1'b1; wr(RA_SHIFT, 32'd0);
  endtask

  task automatic t_timeout();
    logic [31:0] d0, d1;
    rd(RA_MEAS, d0);
    wr(RA_ENMASK, 32'h3); wr(RA_TMO, 32'd3); wr(RA_POLL, 32'd2);
    salt = 32'd55; miss_left = 3;
    one_sweep();
    chk(lg_n == 4, "R7 reads", 32'(lg_n), 32'd4);
    rd(RA_MEAS, d1); chk(d1 == d0, "R7 meas kept", d1, d0);
    rd(RA_MEAS + 5'd1, d1);
    chk(d1 == (lg_data[3] & 32'hFFFF), "R7 next slot", d1, lg_data[3] & 32'hFFFF);
    wr(RA_ENMASK, 32'h1); wr(RA_TMO, 32'd0); miss_left = 5;
    one_sweep();
    chk(lg_n == 1, "R7 zero timeout", 32'(lg_n), 32'd1);
    miss_left = 0;
  endtask

  task automatic t_interval();
    wr(RA_ENMASK, 32'h1); wr(RA_WRCTL, 32'h0);
    lg_n = 0;
    wr(RA_PERIOD, 32'd1);
    wait_log(3);
    wr(RA_PERIOD, 32'd0);
    chk(lg_t[1] - lg_t[0] == 512, "R2 gap a", 32'(lg_t[1] - lg_t[0]), 32'd512);
    chk(lg_t[2] - lg_t[1] == 512, "R2 gap b", 32'(lg_t[2] - lg_t[1]), 32'd512);
    repeat (50) @(negedge clk);
    wr(RA_INTV, 32'd3); lg_n = 0;
    wr(RA_PERIOD, 32'd1);
    wait_log(2);
    wr(RA_PERIOD, 32'd0);
    chk(lg_t[1] - lg_t[0] == 768, "R2 gap c", 32'(lg_t[1] - lg_t[0]), 32'd768);
    repeat (50) @(negedge clk);
    lg_n = 0;
    repeat (2000) @(negedge clk);
    chk(lg_n == 0, "R2 period zero", 32'(lg_n), 32'd0);
    wr(RA_INTV, 32'd0); wr(RA_PERIOD, 32'd1);
    repeat (2000) @(negedge clk);
    chk(lg_n == 0, "R2 interval zero", 32'(lg_n), 32'd0);
    wr(RA_PERIOD, 32'd0); wr(RA_INTV, 32'd2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_readback();
    setup_common();
    t_full();
    t_sparse();
    t_poll();
    t_polarity();
    t_timeout();
    t_interval();
    finished = 1;
    summary();
  end
endmodule